// File: doc/BRIEF.md
# Partitioned SIMD Lane Adder

This block adds two 128-bit packed vectors element by element. A two-bit lane-size selector decides at run time whether the vector is treated as sixteen 8-bit elements, eight 16-bit elements or four 32-bit elements. The same addition is applied to every element pair in parallel. Element i of each source produces element i of the result.

Internally the vector is split into 8-bit segments that form a single ripple carry chain. The lane-size selector cuts that chain at each element boundary, so carries never cross from one element into the next. Each element therefore wraps modulo 2 to the power of its width.

The operands are presented together with a valid strobe. The sum and a valid flag appear at the outputs one clock later. When the strobe is low the result register keeps its previous value. A synchronous active-high reset clears both the result and the flag.

Top module: `simd_lane_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` is cleared to 0 and `out_sum` is cleared to all zeros.
- R2: `out_valid` is high in the cycle after a rising edge where `in_valid` was high. It is low in the cycle after a rising edge where `in_valid` was low.
- R3: With `lane_mode` = 2'b00, result bits [8i+7:8i] equal (src_a[8i+7:8i] + src_b[8i+7:8i]) mod 256 for i = 0..15.
- R4: With `lane_mode` = 2'b01, result bits [16i+15:16i] equal the sum of the matching source fields mod 2^16 for i = 0..7.
- R5: With `lane_mode` = 2'b10, result bits [32i+31:32i] equal the sum of the matching source fields mod 2^32 for i = 0..3.
- R6: `lane_mode` = 2'b11 gives exactly the 32-bit element result of R5.
- R7: No carry crosses an element boundary. For example, all ones plus 1 leaves every element above element 0 at all ones in every mode.
- R8: When `in_valid` is low at a rising edge, `out_sum` keeps its previous value, whatever the operands and mode are.
- R9: Inside an element, a carry does propagate across the internal 8-bit segment boundaries. For example, 16'h00FF + 16'h0001 = 16'h0100 in 16-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| lane_mode | input | 2 | Element size: 00 = 8-bit, 01 = 16-bit, 10 or 11 = 32-bit |
| src_a | input | 128 | First packed source vector |
| src_b | input | 128 | Second packed source vector |
| out_valid | output | 1 | Registered result is new this cycle |
| out_sum | output | 128 | Registered packed sum |

## Verification
A table of mixed operands is run in all four mode codes. This shows that each mode places its element boundaries at the right bit positions, and that code 11 matches code 10. All-ones plus one shows whether a carry leaks out of element 0, which a plain full-width adder would do. Repeated 8'h80 bytes produce a different answer in every element size, so a wrong boundary set in any mode shows up as a wrong value. The pattern 00FF + 0001 shows that carries still cross the internal byte seams inside wider elements. A strobe-low cycle with changed operands shows whether the register reloads when it should hold.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

    localparam int VEC_W     = 128;
    localparam int SEG_W     = 8;
    localparam int NUM_SEG   = VEC_W / SEG_W;
    localparam int MODE_W    = 2;

    typedef enum logic [MODE_W-1:0] {
        LM_E8   = 2'b00,
        LM_E16  = 2'b01,
        LM_E32  = 2'b10,
        LM_E32X = 2'b11
    } lane_mode_e;

    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic valid;
        vec_t data;
    } vec_beat_t;

    // Number of 8-bit segments that make up one element in a given mode.
    function automatic int segs_per_elem(lane_mode_e m);
        case (m)
            LM_E8:   return 1;
            LM_E16:  return 2;
            default: return 4;
        endcase
    endfunction

    // Bit k set: segment k begins a new element, so its carry-in is forced low.
    function automatic logic [NUM_SEG-1:0] elem_start_mask(lane_mode_e m);
        logic [NUM_SEG-1:0] mask;
        int spe;
        spe = segs_per_elem(m);
        for (int k = 0; k < NUM_SEG; k++) begin
            mask[k] = ((k % spe) == 0);
        end
        return mask;
    endfunction

endpackage

// File: rtl/simd_lane_boundary.sv
module simd_lane_boundary
    import simd_add_pkg::*;
#(
    parameter int N_SEG = simd_add_pkg::NUM_SEG
) (
    input  lane_mode_e         mode,
    output logic [N_SEG-1:0]   seg_cut
);

    logic [N_SEG-1:0] cut_e8;
    logic [N_SEG-1:0] cut_e16;
    logic [N_SEG-1:0] cut_e32;

    // Static boundary patterns for each element size, picked at run time.
    for (genvar k = 0; k < N_SEG; k++) begin : g_pat
        assign cut_e8[k]  = 1'b1;
        assign cut_e16[k] = ((k % 2) == 0);
        assign cut_e32[k] = ((k % 4) == 0);
    end

    always_comb begin
        case (mode)
            LM_E8:   seg_cut = cut_e8;
            LM_E16:  seg_cut = cut_e16;
            default: seg_cut = cut_e32;
        endcase
    end

endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
    parameter int W = simd_add_pkg::SEG_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
    end

endmodule

// File: rtl/simd_beat_reg.sv
module simd_beat_reg
    import simd_add_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  vec_t      d,
    output vec_beat_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= load;
            if (load) begin
                q.data <= d;
            end
        end
    end

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
    import simd_add_pkg::*;
#(
    parameter int V_W  = simd_add_pkg::VEC_W,
    parameter int S_W  = simd_add_pkg::SEG_W,
    localparam int N_S = V_W / S_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       lane_mode,
    input  logic [V_W-1:0]   src_a,
    input  logic [V_W-1:0]   src_b,
    output logic             out_valid,
    output logic [V_W-1:0]   out_sum
);

    lane_mode_e        mode_q;
    logic [N_S-1:0]    seg_cut;
    logic [N_S-1:0]    seg_cin;
    logic [N_S-1:0]    seg_cout;
    logic [V_W-1:0]    raw_sum;
    vec_beat_t         beat;

    assign mode_q = lane_mode_e'(lane_mode);

    simd_lane_boundary #(.N_SEG(N_S)) u_boundary (
        .mode    (mode_q),
        .seg_cut (seg_cut)
    );

    // One ripple chain across all segments, cut where an element begins.
    for (genvar k = 0; k < N_S; k++) begin : g_seg
        if (k == 0) begin : g_first
            assign seg_cin[k] = 1'b0;
        end else begin : g_rest
            assign seg_cin[k] = seg_cut[k] ? 1'b0 : seg_cout[k-1];
        end

        simd_seg_adder #(.W(S_W)) u_seg (
            .a    (src_a[k*S_W +: S_W]),
            .b    (src_b[k*S_W +: S_W]),
            .cin  (seg_cin[k]),
            .sum  (raw_sum[k*S_W +: S_W]),
            .cout (seg_cout[k])
        );
    end

    simd_beat_reg u_out (
        .clk  (clk),
        .rst  (rst),
        .load (in_valid),
        .d    (raw_sum),
        .q    (beat)
    );

    assign out_valid = beat.valid;
    assign out_sum   = beat.data;

endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk #(
    parameter int V_W = 128
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [1:0]     lane_mode,
    input logic [V_W-1:0] src_a,
    input logic [V_W-1:0] src_b,
    input logic           out_valid,
    input logic [V_W-1:0] out_sum
);

    // Bit-serial reference: carry restarts at each element's lowest bit.
    function automatic logic [V_W-1:0] bitwise_ref(logic [1:0] m,
                                                   logic [V_W-1:0] a,
                                                   logic [V_W-1:0] b);
        logic [V_W-1:0] r;
        logic c;
        int ew;
        ew = (m == 2'b00) ? 8 : (m == 2'b01) ? 16 : 32;
        c = 1'b0;
        for (int i = 0; i < V_W; i++) begin
            if ((i % ew) == 0) c = 1'b0;
            r[i] = a[i] ^ b[i] ^ c;
            c    = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
        end
        return r;
    endfunction

    logic [V_W-1:0] exp_sum;
    assign exp_sum = bitwise_ref(lane_mode, src_a, src_b);

    AST_RST_CLEAR:  assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!out_valid && out_sum == '0)); // R1
    AST_VALID_SET:  assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R2
    AST_SUM_E8:     assert property (@(posedge clk) disable iff (rst) (in_valid && lane_mode == 2'b00) |=> out_sum == $past(exp_sum)); // R3
    AST_SUM_E16:    assert property (@(posedge clk) disable iff (rst) (in_valid && lane_mode == 2'b01) |=> out_sum == $past(exp_sum)); // R4
    AST_SUM_E32:    assert property (@(posedge clk) disable iff (rst) (in_valid && lane_mode == 2'b10) |=> out_sum == $past(exp_sum)); // R5
    AST_SUM_E32X:   assert property (@(posedge clk) disable iff (rst) (in_valid && lane_mode == 2'b11) |=> out_sum == $past(exp_sum)); // R6
    AST_HOLD:       assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_sum)); // R8

endmodule

bind simd_lane_adder simd_lane_adder_chk #(.V_W(V_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .lane_mode (lane_mode),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/simd_lane_adder_bench.sv
module simd_lane_adder_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   lane_mode;
    logic [127:0] src_a;
    logic [127:0] src_b;
    logic         out_valid;
    logic [127:0] out_sum;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    simd_lane_adder u_simd_lane_adder (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .lane_mode (lane_mode),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    typedef struct packed {
        logic [1:0]   mode;
        logic [127:0] a;
        logic [127:0] b;
    } stim_t;

    localparam int N_STIM = 8;
    localparam stim_t STIM [N_STIM] = '{
        '{2'b00, 128'h0123456789ABCDEF_FEDCBA9876543210, 128'hF0E1D2C3B4A59687_78695A4B3C2D1E0F},
        '{2'b01, 128'h0123456789ABCDEF_FEDCBA9876543210, 128'hF0E1D2C3B4A59687_78695A4B3C2D1E0F},
        '{2'b10, 128'h0123456789ABCDEF_FEDCBA9876543210, 128'hF0E1D2C3B4A59687_78695A4B3C2D1E0F},
        '{2'b11, 128'h0123456789ABCDEF_FEDCBA9876543210, 128'hF0E1D2C3B4A59687_78695A4B3C2D1E0F},
        '{2'b00, 128'hDEADBEEFCAFEF00D_8BADF00DFEEDFACE, 128'h1357924680ACE135_FFFF0000FFFF0000},
        '{2'b01, 128'hDEADBEEFCAFEF00D_8BADF00DFEEDFACE, 128'h1357924680ACE135_FFFF0000FFFF0000},
        '{2'b10, 128'hDEADBEEFCAFEF00D_8BADF00DFEEDFACE, 128'h1357924680ACE135_FFFF0000FFFF0000},
        '{2'b11, 128'h7FFFFFFF80000000_FFFFFFFF00000001, 128'h0000000180000000_00000001FFFFFFFF}
    };

    // Element-wise model written from the requirements.
    function automatic logic [127:0] model(logic [1:0] m, logic [127:0] a, logic [127:0] b);
        logic [127:0] r;
        logic [31:0]  x, y, s, msk;
        int w;
        w   = (m == 2'b00) ? 8 : (m == 2'b01) ? 16 : 32;
        msk = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        r   = '0;
        for (int l = 0; l < 128 / w; l++) begin
            x = 32'(a >> (l * w)) & msk;
            y = 32'(b >> (l * w)) & msk;
            s = (x + y) & msk;
            r = r | (128'(s) << (l * w));
        end
        return r;
    endfunction

    task automatic check_vec(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Present one operation, then sample the registered result one cycle later.
    task automatic run_op(logic [1:0] m, logic [127:0] a, logic [127:0] b);
        @(negedge clk);
        lane_mode = m;
        src_a     = a;
        src_b     = b;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    function automatic string mode_req(logic [1:0] m);
        case (m)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        rst       = 1'b1;
        in_valid  = 1'b1;
        lane_mode = 2'b00;
        src_a     = {128{1'b1}};
        src_b     = {128{1'b1}};
        repeat (3) @(negedge clk);
        // R1: reset dominates an active strobe
        check_bit("R1 valid", out_valid, 1'b0);
        check_vec("R1 sum", out_sum, '0);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R2 idle", out_valid, 1'b0);

        // Table walk
        for (int i = 0; i < N_STIM; i++) begin
            run_op(STIM[i].mode, STIM[i].a, STIM[i].b);
            check_bit("R2 valid", out_valid, 1'b1);
            check_vec(mode_req(STIM[i].mode), out_sum, model(STIM[i].mode, STIM[i].a, STIM[i].b));
        end

        // R7: all ones + 1 in every mode
        run_op(2'b00, {128{1'b1}}, 128'h1);
        check_vec("R7 e8", out_sum, {{120{1'b1}}, 8'h00});
        run_op(2'b01, {128{1'b1}}, 128'h1);
        check_vec("R7 e16", out_sum, {{112{1'b1}}, 16'h0000});
        run_op(2'b10, {128{1'b1}}, 128'h1);
        check_vec("R7 e32", out_sum, {{96{1'b1}}, 32'h0000_0000});
        run_op(2'b11, {128{1'b1}}, 128'h1);
        check_vec("R7 R6 e32x", out_sum, {{96{1'b1}}, 32'h0000_0000});

        // Repeated 8'h80 gives a different answer per element size
        run_op(2'b00, {16{8'h80}}, {16{8'h80}});
        check_vec("R3 R7 80s", out_sum, '0);
        run_op(2'b01, {16{8'h80}}, {16{8'h80}});
        check_vec("R4 R9 80s", out_sum, {8{16'h0100}});
        run_op(2'b10, {16{8'h80}}, {16{8'h80}});
        check_vec("R5 R9 80s", out_sum, {4{32'h0101_0100}});
        run_op(2'b11, {16{8'h80}}, {16{8'h80}});
        check_vec("R6 80s", out_sum, {4{32'h0101_0100}});

        // R9: carry crosses byte seam inside a 16-bit element, not in 8-bit mode
        run_op(2'b01, {8{16'h00FF}}, {8{16'h0001}});
        check_vec("R9 e16", out_sum, {8{16'h0100}});
        run_op(2'b00, {8{16'h00FF}}, {8{16'h0001}});
        check_vec("R9 e8", out_sum, '0);

        // R8: strobe low with new operands leaves the result alone
        held = out_sum;
        @(negedge clk);
        lane_mode = 2'b10;
        src_a     = {128{1'b1}};
        src_b     = {4{32'h1234_5678}};
        @(negedge clk);
        @(negedge clk);
        check_vec("R8 hold", out_sum, held);
        check_bit("R2 low", out_valid, 1'b0);

        // R1: reset mid-run clears a loaded result
        run_op(2'b10, {4{32'h1}}, {4{32'h2}});
        check_vec("R5 pre-reset", out_sum, {4{32'h3}});
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_vec("R1 mid", out_sum, '0);
        check_bit("R1 mid valid", out_valid, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule